// File: doc/BRIEF.md
# Page Frame Replacement Tracker

This block keeps track of a small pool of physical page frames. Each frame holds one 8-bit page tag. Page references arrive one per cycle over a valid/ready handshake. For each accepted reference the block decides whether the page is already resident (a hit) or must be brought in (a fault). It then reports the outcome and the frame index that was hit or filled.

A running fault counter is published next to each result. Because of this, the same reference stream can be replayed under different replacement policies, and the fault totals can be compared directly. This includes the case where giving FIFO more frames produces more faults.

The policy is chosen by a static two-bit input that is held steady between resets:

| Code | Policy |
|------|--------|
| 0 | oldest-loaded (FIFO) |
| 1 | least-recently-referenced (LRU) |
| 2 | least-frequently-referenced (LFU) |
| 3 | oldest-loaded (FIFO) |

A missing page always goes into the lowest-numbered empty frame while one exists. Only a pool with no empty frame asks the policy for a victim. The number of frames is a parameter from 2 to 8.

Top module: `pfr_tracker`

## Requirements
- R1: While reset is asserted, `ref_ready_o` is 0. After reset, every frame is empty, `res_valid_o` is 0 and `fault_count_o` is 0. As a result, the first reference after reset misses into frame 0 whatever was resident before.
- R2: `ref_ready_o` is 1 in every cycle out of reset. Each reference accepted at a clock edge produces `res_valid_o`=1 in the following cycle. When no reference is accepted, `res_valid_o` is 0 in the following cycle. Back-to-back references give back-to-back results.
- R3: A reference to a resident tag returns `res_hit_o`=1 and the index of the frame holding that tag, and leaves `fault_count_o` unchanged.
- R4: A reference to a non-resident tag returns `res_hit_o`=0. It raises `fault_count_o` by one in the same cycle as the result. The counter saturates at its all-ones value.
- R5: A non-resident tag always faults, even when empty frames remain. While any frame is empty, the tag is placed in the lowest-indexed empty frame, and frames fill in order 0, 1, 2, and so on, before any eviction.
- R6: With policy code 0 or 3 (FIFO), the victim is the frame loaded longest ago. Hits do not change this order. With 3 frames, the stream B,E,E,R,B,A,R,E,B,E,A,R yields 7 faults.
- R7: With policy code 1 (LRU), the victim is the frame whose last reference (hit or load) is oldest. With 3 frames, the stream B,E,E,R,B,A,R,E,B,E,A,R yields 8 faults.
- R8: With policy code 2 (LFU), the victim is the frame with the smallest reference count.
  - Each hit adds one to a frame's count, saturating.
  - A newly loaded page starts at count 1.
  - Equal counts are resolved toward the lowest frame index.
  - With 3 frames, the stream B,E,E,R,B,A,R,E,B,E,A,R yields 7 faults.
- R9: Under FIFO, the stream A,B,C,D,A,B,E,A,B,C,D,E yields 9 faults with 3 frames and 10 faults with 4 frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Replacement policy code (see the table above), static between resets |
| ref_valid_i | input | 1 | A page reference is offered |
| ref_ready_o | output | 1 | The block can accept a reference |
| ref_tag_i | input | TAG_W | Tag of the referenced page |
| res_valid_o | output | 1 | Result of the previous accepted reference is present |
| res_hit_o | output | 1 | 1 = page was resident, 0 = fault |
| res_frame_o | output | clog2(N_FRAMES) | Frame hit or filled |
| fault_count_o | output | FAULT_W | Faults since reset, saturating |

## Verification
The same twelve-reference stream is replayed under each of the three policies, and every reference's hit bit and frame index is compared with a hand-traced expectation. This separates oldest-loaded, least-recent and least-frequent victim choice, because the three policies diverge at specific references in that stream. A second stream is replayed under FIFO on a 3-frame and a 4-frame instance to show the fault count rising with the larger pool.

Directed sequences cover three further points:
- A pinned LFU tie shows that ties go to the lower index and that a new page restarts at count 1.
- A short run with code 3 evicts the same frame that FIFO would, where LRU would pick a different frame.
- A long stream of distinct tags drives the narrow fault counter into saturation.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
    typedef enum logic [1:0] {
        POL_FIFO     = 2'd0,
        POL_LRU      = 2'd1,
        POL_LFU      = 2'd2,
        POL_FIFO_ALT = 2'd3
    } policy_e;
endpackage

// File: rtl/pfr_lookup.sv
// Associative match of the incoming tag against all resident frames, plus
// a lowest-index search for an empty frame.
module pfr_lookup #(
    parameter int N_FRAMES = 3,
    parameter int TAG_W    = 8,
    parameter int IDX_W    = 2
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic [N_FRAMES-1:0]            valid_i,
    input  logic [N_FRAMES-1:0][TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0]               ref_tag_i,
    output logic                           hit_o,
    output logic [IDX_W-1:0]               hit_idx_o,
    output logic                           free_o,
    output logic [IDX_W-1:0]               free_idx_o
);
    logic [N_FRAMES-1:0] hit_vec;

    for (genvar g = 0; g < N_FRAMES; g++) begin : g_cmp
        assign hit_vec[g] = valid_i[g] && (tag_i[g] == ref_tag_i);
    end

    always_comb begin
        hit_idx_o  = '0;
        free_idx_o = '0;
        for (int i = N_FRAMES - 1; i >= 0; i--) begin
            if (hit_vec[i])  hit_idx_o  = IDX_W'(i);
            if (!valid_i[i]) free_idx_o = IDX_W'(i);
        end
    end

    assign hit_o  = |hit_vec;
    assign free_o = ~&valid_i;

    // R3
    unique_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit_vec));
endmodule

// File: rtl/pfr_victim.sv
// Victim choice for a full pool: oldest rank for FIFO/LRU, smallest count
// (lowest index on ties) for LFU.
module pfr_victim #(
    parameter int N_FRAMES = 3,
    parameter int IDX_W    = 2,
    parameter int CNT_W    = 4
) (
    input  pfr_pkg::policy_e               policy_i,
    input  logic [N_FRAMES-1:0][IDX_W-1:0] rank_i,
    input  logic [N_FRAMES-1:0][CNT_W-1:0] uses_i,
    output logic [IDX_W-1:0]               victim_o
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N_FRAMES - 1);

    logic [IDX_W-1:0] old_idx;
    logic [IDX_W-1:0] min_idx;
    logic [CNT_W-1:0] min_cnt;

    always_comb begin
        old_idx = '0;
        min_idx = '0;
        min_cnt = uses_i[0];
        for (int i = 0; i < N_FRAMES; i++) begin
            if (rank_i[i] == OLDEST) old_idx = IDX_W'(i);
            if (uses_i[i] < min_cnt) begin
                min_cnt = uses_i[i];
                min_idx = IDX_W'(i);
            end
        end
        victim_o = (policy_i == pfr_pkg::POL_LFU) ? min_idx : old_idx;
    end
endmodule

// File: rtl/pfr_tracker.sv
module pfr_tracker #(
    parameter int N_FRAMES = 3,
    parameter int TAG_W    = 8,
    parameter int CNT_W    = 4,
    parameter int FAULT_W  = 16
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [1:0]                    policy_i,
    input  logic                          ref_valid_i,
    output logic                          ref_ready_o,
    input  logic [TAG_W-1:0]              ref_tag_i,
    output logic                          res_valid_o,
    output logic                          res_hit_o,
    output logic [$clog2(N_FRAMES)-1:0]   res_frame_o,
    output logic [FAULT_W-1:0]            fault_count_o
);
    localparam int IDX_W = $clog2(N_FRAMES);
    localparam logic [FAULT_W-1:0] FAULT_MAX = '1;
    localparam logic [CNT_W-1:0]   USE_MAX   = '1;

    typedef struct packed {
        logic [N_FRAMES-1:0]            valid;
        logic [N_FRAMES-1:0][TAG_W-1:0] tag;
        logic [N_FRAMES-1:0][IDX_W-1:0] rank;
        logic [N_FRAMES-1:0][CNT_W-1:0] uses;
        logic [FAULT_W-1:0]             faults;
        logic                           ready;
        logic                           res_valid;
        logic                           res_hit;
        logic [IDX_W-1:0]               res_frame;
    } state_t;

    state_t state_q, state_d;

    pfr_pkg::policy_e policy;
    logic             hit, free;
    logic [IDX_W-1:0] hit_idx, free_idx, victim_idx, tgt;
    logic [IDX_W:0]   old_rank;
    logic             accept, touch;

    assign policy = pfr_pkg::policy_e'(policy_i);
    assign accept = ref_valid_i && state_q.ready;

    pfr_lookup #(.N_FRAMES(N_FRAMES), .TAG_W(TAG_W), .IDX_W(IDX_W)) i_lookup (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .valid_i    (state_q.valid),
        .tag_i      (state_q.tag),
        .ref_tag_i  (ref_tag_i),
        .hit_o      (hit),
        .hit_idx_o  (hit_idx),
        .free_o     (free),
        .free_idx_o (free_idx)
    );

    pfr_victim #(.N_FRAMES(N_FRAMES), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_victim (
        .policy_i (policy),
        .rank_i   (state_q.rank),
        .uses_i   (state_q.uses),
        .victim_o (victim_idx)
    );

    always_comb begin
        state_d           = state_q;
        state_d.ready     = 1'b1;
        state_d.res_valid = accept;
        tgt      = hit ? hit_idx : (free ? free_idx : victim_idx);
        touch    = !hit || (policy == pfr_pkg::POL_LRU);
        // An empty frame counts as older than every resident one.
        old_rank = (!hit && !state_q.valid[tgt]) ? (IDX_W+1)'(N_FRAMES)
                                                 : {1'b0, state_q.rank[tgt]};
        if (accept) begin
            state_d.res_hit   = hit;
            state_d.res_frame = tgt;
            if (hit) begin
                if (state_q.uses[tgt] != USE_MAX)
                    state_d.uses[tgt] = state_q.uses[tgt] + 1'b1;
            end else begin
                if (state_q.faults != FAULT_MAX)
                    state_d.faults = state_q.faults + 1'b1;
                state_d.valid[tgt] = 1'b1;
                state_d.tag[tgt]   = ref_tag_i;
                state_d.uses[tgt]  = CNT_W'(1);
            end
            if (touch) begin
                for (int i = 0; i < N_FRAMES; i++) begin
                    if (IDX_W'(i) != tgt && state_q.valid[i] &&
                        ({1'b0, state_q.rank[i]} < old_rank))
                        state_d.rank[i] = state_q.rank[i] + 1'b1;
                end
                state_d.rank[tgt] = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign ref_ready_o   = state_q.ready;
    assign res_valid_o   = state_q.res_valid;
    assign res_hit_o     = state_q.res_hit;
    assign res_frame_o   = state_q.res_frame;
    assign fault_count_o = state_q.faults;

    // R2
    result_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_valid_i && ref_ready_o) |=> res_valid_o);
    // R2
    idle_no_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ref_valid_i && ref_ready_o) |=> !res_valid_o);
    // R3
    hit_count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && res_hit_o) |-> $stable(fault_count_o));
    // R4
    miss_count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_valid_o && !res_hit_o && $past(fault_count_o) != FAULT_MAX)
        |-> fault_count_o == $past(fault_count_o) + 1'b1);
    // R5
    frame_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> ({1'b0, res_frame_o} < (IDX_W+1)'(N_FRAMES)));
endmodule

// File: tb/test_pfr_tracker.sv
`timescale 1ns/1ps
module test_pfr_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pol = 2'd0;
    always #2.5 clk = ~clk;

    logic       v3 = 1'b0, v4 = 1'b0;
    logic [7:0] t3 = '0, t4 = '0;
    logic       rdy3, rdy4, rv3, rv4, h3, h4;
    logic [1:0] f3, f4;
    logic [15:0] fc3;
    logic [3:0]  fc4;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pfr_tracker #(.N_FRAMES(3), .TAG_W(8), .CNT_W(4), .FAULT_W(16)) i_pfr_tracker (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .ref_valid_i(v3),
        .ref_ready_o(rdy3), .ref_tag_i(t3), .res_valid_o(rv3), .res_hit_o(h3),
        .res_frame_o(f3), .fault_count_o(fc3));

    pfr_tracker #(.N_FRAMES(4), .TAG_W(8), .CNT_W(4), .FAULT_W(4)) i_pfr_tracker_4 (
        .clk_i(clk), .rst_ni(rst_n), .policy_i(pol), .ref_valid_i(v4),
        .ref_ready_o(rdy4), .ref_tag_i(t4), .res_valid_o(rv4), .res_hit_o(h4),
        .res_frame_o(f4), .fault_count_o(fc4));

    // {wide, policy, tag, hit, frame}
    localparam int NV = 60;
    localparam logic [14:0] VEC [NV] = '{
        // FIFO, 3 frames, B E E R B A R E B E A R
        {1'b0,2'd0,8'h42,1'b0,3'd0}, {1'b0,2'd0,8'h45,1'b0,3'd1},
        {1'b0,2'd0,8'h45,1'b1,3'd1}, {1'b0,2'd0,8'h52,1'b0,3'd2},
        {1'b0,2'd0,8'h42,1'b1,3'd0}, {1'b0,2'd0,8'h41,1'b0,3'd0},
        {1'b0,2'd0,8'h52,1'b1,3'd2}, {1'b0,2'd0,8'h45,1'b1,3'd1},
        {1'b0,2'd0,8'h42,1'b0,3'd1}, {1'b0,2'd0,8'h45,1'b0,3'd2},
        {1'b0,2'd0,8'h41,1'b1,3'd0}, {1'b0,2'd0,8'h52,1'b0,3'd0},
        // LRU, 3 frames
        {1'b0,2'd1,8'h42,1'b0,3'd0}, {1'b0,2'd1,8'h45,1'b0,3'd1},
        {1'b0,2'd1,8'h45,1'b1,3'd1}, {1'b0,2'd1,8'h52,1'b0,3'd2},
        {1'b0,2'd1,8'h42,1'b1,3'd0}, {1'b0,2'd1,8'h41,1'b0,3'd1},
        {1'b0,2'd1,8'h52,1'b1,3'd2}, {1'b0,2'd1,8'h45,1'b0,3'd0},
        {1'b0,2'd1,8'h42,1'b0,3'd1}, {1'b0,2'd1,8'h45,1'b1,3'd0},
        {1'b0,2'd1,8'h41,1'b0,3'd2}, {1'b0,2'd1,8'h52,1'b0,3'd1},
        // LFU, 3 frames
        {1'b0,2'd2,8'h42,1'b0,3'd0}, {1'b0,2'd2,8'h45,1'b0,3'd1},
        {1'b0,2'd2,8'h45,1'b1,3'd1}, {1'b0,2'd2,8'h52,1'b0,3'd2},
        {1'b0,2'd2,8'h42,1'b1,3'd0}, {1'b0,2'd2,8'h41,1'b0,3'd2},
        {1'b0,2'd2,8'h52,1'b0,3'd2}, {1'b0,2'd2,8'h45,1'b1,3'd1},
        {1'b0,2'd2,8'h42,1'b1,3'd0}, {1'b0,2'd2,8'h45,1'b1,3'd1},
        {1'b0,2'd2,8'h41,1'b0,3'd2}, {1'b0,2'd2,8'h52,1'b0,3'd2},
        // FIFO, 3 frames, A B C D A B E A B C D E
        {1'b0,2'd0,8'h41,1'b0,3'd0}, {1'b0,2'd0,8'h42,1'b0,3'd1},
        {1'b0,2'd0,8'h43,1'b0,3'd2}, {1'b0,2'd0,8'h44,1'b0,3'd0},
        {1'b0,2'd0,8'h41,1'b0,3'd1}, {1'b0,2'd0,8'h42,1'b0,3'd2},
        {1'b0,2'd0,8'h45,1'b0,3'd0}, {1'b0,2'd0,8'h41,1'b1,3'd1},
        {1'b0,2'd0,8'h42,1'b1,3'd2}, {1'b0,2'd0,8'h43,1'b0,3'd1},
        {1'b0,2'd0,8'h44,1'b0,3'd2}, {1'b0,2'd0,8'h45,1'b1,3'd0},
        // FIFO, 4 frames, same stream
        {1'b1,2'd0,8'h41,1'b0,3'd0}, {1'b1,2'd0,8'h42,1'b0,3'd1},
        {1'b1,2'd0,8'h43,1'b0,3'd2}, {1'b1,2'd0,8'h44,1'b0,3'd3},
        {1'b1,2'd0,8'h41,1'b1,3'd0}, {1'b1,2'd0,8'h42,1'b1,3'd1},
        {1'b1,2'd0,8'h45,1'b0,3'd0}, {1'b1,2'd0,8'h41,1'b0,3'd1},
        {1'b1,2'd0,8'h42,1'b0,3'd2}, {1'b1,2'd0,8'h43,1'b0,3'd3},
        {1'b1,2'd0,8'h44,1'b0,3'd0}, {1'b1,2'd0,8'h45,1'b0,3'd1}
    };
    localparam int EXP_FAULTS [5] = '{7, 8, 7, 9, 10};

    function automatic string stream_req(input int s);
        case (s)
            0: return "R6";
            1: return "R7";
            2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] p);
        @(negedge clk);
        rst_n = 1'b0;
        pol   = p;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Offer one reference; on return the result is on the outputs.
    task automatic send(input bit wide, input logic [7:0] tag);
        if (wide) begin v4 = 1'b1; t4 = tag; end
        else      begin v3 = 1'b1; t3 = tag; end
        @(negedge clk);
        v3 = 1'b0;
        v4 = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        chk("R1 ready low in reset", int'(rdy3), 0);
        do_reset(2'd0);
        chk("R1 ready after reset", int'(rdy3), 1);
        chk("R1 no result after reset", int'(rv3), 0);
        chk("R1 fault count zero", int'(fc3), 0);
        chk("R1 fault count zero 4f", int'(fc4), 0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            logic [14:0] e;
            e = VEC[k];
            if (k % 12 == 0) do_reset(e[13:12]);
            send(e[14], e[11:4]);
            if (e[14]) begin
                chk({stream_req(k/12), " R2 result valid"}, int'(rv4), 1);
                chk({stream_req(k/12), " R3/R4 hit"}, int'(h4), int'(e[3]));
                chk({stream_req(k/12), " R5 frame"}, int'(f4), int'(e[2:0]));
            end else begin
                chk({stream_req(k/12), " R2 result valid"}, int'(rv3), 1);
                chk({stream_req(k/12), " R3/R4 hit"}, int'(h3), int'(e[3]));
                chk({stream_req(k/12), " R5 frame"}, int'(f3), int'(e[2:0]));
            end
            if (k % 12 == 11)
                chk({stream_req(k/12), " total faults"},
                    e[14] ? int'(fc4) : int'(fc3), EXP_FAULTS[k/12]);
        end

        // R1: reset empties frames that were full before
        do_reset(2'd0);
        send(1'b0, 8'h45);
        chk("R1 post-reset miss", int'(h3), 0);
        chk("R1 post-reset frame", int'(f3), 0);

        // R2: idle gives no result; back-to-back gives consecutive results
        do_reset(2'd0);
        @(negedge clk);
        chk("R2 idle no result", int'(rv3), 0);
        v3 = 1'b1; t3 = 8'h10;
        @(negedge clk);
        t3 = 8'h11;
        chk("R2 b2b first valid", int'(rv3), 1);
        chk("R5 b2b first frame", int'(f3), 0);
        @(negedge clk);
        v3 = 1'b0;
        chk("R2 b2b second valid", int'(rv3), 1);
        chk("R5 b2b second frame", int'(f3), 1);
        @(negedge clk);
        chk("R2 result drops", int'(rv3), 0);

        // R4 saturation, R5 ascending fill on 4-frame instance
        do_reset(2'd0);
        for (int i = 0; i < 20; i++) begin
            send(1'b1, 8'h60 + 8'(i));
            if (i < 4) chk("R5 ascending fill", int'(f4), i);
            if (i == 4) chk("R6 first eviction oldest", int'(f4), 0);
        end
        chk("R4 fault count saturates", int'(fc4), 15);

        // R8: LFU tie-break and new-page count
        do_reset(2'd2);
        send(1'b0, 8'h71); send(1'b0, 8'h72); send(1'b0, 8'h73);
        send(1'b0, 8'h71); send(1'b0, 8'h71); send(1'b0, 8'h72);
        send(1'b0, 8'h74);
        chk("R8 evict smallest count", int'(f3), 2);
        send(1'b0, 8'h75);
        chk("R8 new page count 1 evicted", int'(f3), 2);
        send(1'b0, 8'h75);
        chk("R8 hit on new page", int'(h3), 1);
        send(1'b0, 8'h76);
        chk("R8 tie to lowest index", int'(f3), 1);
        chk("R8 fault total", int'(fc3), 6);

        // R6: code 3 behaves as FIFO
        do_reset(2'd3);
        send(1'b0, 8'h41); send(1'b0, 8'h42); send(1'b0, 8'h43);
        send(1'b0, 8'h41);
        chk("R6 code3 hit", int'(h3), 1);
        send(1'b0, 8'h44);
        chk("R6 code3 evicts oldest", int'(f3), 0);
        send(1'b0, 8'h41);
        chk("R6 code3 refault", int'(h3), 0);
        chk("R6 code3 refault frame", int'(f3), 1);

        done = 1'b1;
        finish_run();
    end
endmodule